// File: doc/BRIEF.md
# Queued multi-lane SPI command sequencer

This block is a half-duplex SPI master that runs from a queue of command words instead of direct pin control. Software pushes 14-bit commands into a command queue, pushes outgoing bytes into a transmit queue and pops incoming bytes from a receive queue. Each command either sets the chip-select level or moves a given number of bytes over one, two or four data lanes. A family of "send then release" commands turns the data pins around to input once the last byte has gone out, so a read command can follow.

The serial clock runs at half the system clock in SPI mode 0 and idles low. A shift command stalls with the clock held low when its queue is not ready: a send waits for a transmit byte, and a receive waits for space in the receive queue. The command-queue empty flag stays low until the last command has fully executed, so software can use it to detect completion.

Top module: `spi_opseq`

## Requirements
- R1: After reset cs_n is 1, sclk is 0, dq_oe is 0000, cmd_empty and rx_empty are 1, and tx_full is 0.
- R2: A command word carries its opcode in bits [13:9] and its byte count in bits [8:0]. Opcode 0x01 drives cs_n low and opcode 0x00 drives it high. Neither changes dq_out or dq_oe.
- R3: Opcodes 0x08, 0x09 and 0x0A send count bytes from the transmit queue, MSB first. They send one bit per sclk rising edge on lane 0, two bits on lanes [1:0] (higher bit on lane 1), or four bits on lanes [3:0] (highest bit on lane 3). dq_oe becomes 0001, 0011 or 1111 and keeps that value after the command ends.
- R4: Opcodes 0x0C, 0x0E and 0x0F receive count bytes, MSB first. They sample lane 1, lanes [1:0] or lanes [3:0] once per sclk high phase and push each completed byte into the receive queue. dq_oe is 0000 while they run, and no byte is driven and sampled at once.
- R5: Opcodes 0x10, 0x11 and 0x12 send like 0x08, 0x09 and 0x0A. dq_oe returns to 0000 once their last byte has gone out.
- R6: cmd_empty is 1 only when the command queue is empty and no command is still executing.
- R7: While rx_empty is 0, rx_rdata shows the oldest received byte. A one-cycle rx_pop moves it to the next byte.
- R8: tx_full rises once the transmit queue holds its depth of bytes. A tx_push while full is dropped.
- R9: A send command whose transmit queue is empty holds sclk low and waits. It resumes when a byte arrives.
- R10: A receive command holds sclk low before a byte while the receive queue is full. It resumes after a pop.
- R11: Undefined opcodes, and shift commands with a count of 0, complete without changing cs_n, dq_out, dq_oe or sclk.
- R12: sclk is high for exactly one system cycle at a time, and dq_out and dq_oe do not change while sclk is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wdata | input | 14 | Command word {opcode, count} |
| cmd_push | input | 1 | Push strobe for the command queue |
| cmd_full | output | 1 | Command queue full |
| cmd_empty | output | 1 | Queue empty and all commands finished |
| tx_wdata | input | 8 | Byte to transmit |
| tx_push | input | 1 | Push strobe for the transmit queue |
| tx_full | output | 1 | Transmit queue full |
| rx_rdata | output | 8 | Oldest received byte |
| rx_pop | input | 1 | Advance the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| sclk | output | 1 | Serial clock, mode 0 |
| cs_n | output | 1 | Chip select, active low |
| dq_out | output | 4 | Data lanes, output value |
| dq_oe | output | 4 | Per-lane output enable |
| dq_in | input | 4 | Data lanes, input value |

## Verification
The bench builds the block with a depth of four for the command, transmit and receive queues. This small depth fills the transmit queue after a handful of pushes, which exercises the dropped-push case. It also lets a six-byte read stall on a full receive queue partway through the command. A slave model shifts a stream of bytes onto the lanes at each falling edge, and a monitor collects the driven bits at each rising edge. Together they cover every lane width in both directions, as well as multi-byte commands that stall and then resume.

// File: rtl/spi_opseq_pkg.sv
package spi_opseq_pkg;

   localparam int OPC_W = 5;
   localparam int CNT_W = 9;
   localparam int CMD_W = OPC_W + CNT_W;
   localparam int BYTE_W = 8;
   localparam int LANE_N = 4;

   typedef enum logic [1:0] {
      LANE_X1 = 2'd0,
      LANE_X2 = 2'd1,
      LANE_X4 = 2'd2
   } lane_t;

   typedef enum logic [2:0] {
      K_CS_HI,
      K_CS_LO,
      K_SEND,
      K_RECV,
      K_SEND_TURN,
      K_NONE
   } kind_t;

   typedef struct packed {
      kind_t kind;
      lane_t lanes;
   } dec_t;

   function automatic dec_t decode_op(input logic [OPC_W-1:0] op);
      dec_t d;
      d.lanes = LANE_X1;
      d.kind  = K_NONE;
      case (op)
         5'h00: d.kind = K_CS_HI;
         5'h01: d.kind = K_CS_LO;
         5'h08: begin d.kind = K_SEND;      d.lanes = LANE_X1; end
         5'h09: begin d.kind = K_SEND;      d.lanes = LANE_X2; end
         5'h0A: begin d.kind = K_SEND;      d.lanes = LANE_X4; end
         5'h0C: begin d.kind = K_RECV;      d.lanes = LANE_X1; end
         5'h0E: begin d.kind = K_RECV;      d.lanes = LANE_X2; end
         5'h0F: begin d.kind = K_RECV;      d.lanes = LANE_X4; end
         5'h10: begin d.kind = K_SEND_TURN; d.lanes = LANE_X1; end
         5'h11: begin d.kind = K_SEND_TURN; d.lanes = LANE_X2; end
         5'h12: begin d.kind = K_SEND_TURN; d.lanes = LANE_X4; end
         default: d.kind = K_NONE;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/spi_opseq_fifo.sv
module spi_opseq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         full,
   output logic         empty
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spi_opseq_fifo: DEPTH must be a power of two of at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("spi_opseq_fifo: W must be positive");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == (AW+1)'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R8: a push into a full queue leaves its occupancy unchanged
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (full && cnt == $past(cnt)));

   // R7: a pop of an empty queue leaves it empty
   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty);

endmodule

// File: rtl/spi_opseq_lanes.sv
module spi_opseq_lanes
   import spi_opseq_pkg::*;
(
   input  lane_t               lanes,
   input  logic [BYTE_W-1:0]   src,
   input  logic [LANE_N-1:0]   dq_in,
   output logic [LANE_N-1:0]   grp_out,
   output logic [BYTE_W-1:0]   shifted,
   output logic [LANE_N-1:0]   oe_mask,
   output logic [2:0]          grp_last
);

   always_comb begin
      case (lanes)
         LANE_X1: begin
            grp_out  = {3'b000, src[7]};
            shifted  = {src[6:0], dq_in[1]};
            oe_mask  = 4'b0001;
            grp_last = 3'd7;
         end
         LANE_X2: begin
            grp_out  = {2'b00, src[7:6]};
            shifted  = {src[5:0], dq_in[1:0]};
            oe_mask  = 4'b0011;
            grp_last = 3'd3;
         end
         default: begin
            grp_out  = src[7:4];
            shifted  = {src[3:0], dq_in[3:0]};
            oe_mask  = 4'b1111;
            grp_last = 3'd1;
         end
      endcase
   end

endmodule

// File: rtl/spi_opseq_engine.sv
module spi_opseq_engine
   import spi_opseq_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CMD_W-1:0]    cmd_head,
   input  logic                cmd_valid,
   output logic                cmd_pop,
   input  logic [BYTE_W-1:0]   tx_head,
   input  logic                tx_empty,
   output logic                tx_pop,
   input  logic                rx_full,
   output logic                rx_push,
   output logic [BYTE_W-1:0]   rx_data,
   output logic                sclk,
   output logic                cs_n,
   output logic [LANE_N-1:0]   dq_out,
   output logic [LANE_N-1:0]   dq_oe,
   input  logic [LANE_N-1:0]   dq_in,
   output logic                busy
);

   typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_LO, ST_HI} st_t;

   st_t                st;
   kind_t              kind;
   lane_t              lanes;
   logic [CNT_W-1:0]   remain;
   logic [2:0]         grp;
   logic [BYTE_W-1:0]  sh;
   logic               cs_q;
   logic [LANE_N-1:0]  dout_q, oe_q;

   dec_t               dec;
   logic [CNT_W-1:0]   cmd_cnt;
   logic               is_out, load_ok;
   logic [BYTE_W-1:0]  lane_src, shifted;
   logic [LANE_N-1:0]  grp_out, oe_mask;
   logic [2:0]         grp_last;

   assign dec      = decode_op(cmd_head[CMD_W-1:CNT_W]);
   assign cmd_cnt  = cmd_head[CNT_W-1:0];
   assign is_out   = (kind == K_SEND) || (kind == K_SEND_TURN);
   assign load_ok  = (st == ST_LOAD) && (is_out ? !tx_empty : !rx_full);
   assign lane_src = (st == ST_LOAD) ? tx_head : sh;

   spi_opseq_lanes u_lanes (
      .lanes    (lanes),
      .src      (lane_src),
      .dq_in    (dq_in),
      .grp_out  (grp_out),
      .shifted  (shifted),
      .oe_mask  (oe_mask),
      .grp_last (grp_last)
   );

   assign cmd_pop = (st == ST_IDLE) && cmd_valid;
   assign tx_pop  = load_ok && is_out;
   assign rx_push = (st == ST_HI) && !is_out && (grp == 3'd0);
   assign rx_data = shifted;
   assign sclk    = (st == ST_HI);
   assign cs_n    = cs_q;
   assign dq_out  = dout_q;
   assign dq_oe   = oe_q;
   assign busy    = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         kind   <= K_NONE;
         lanes  <= LANE_X1;
         remain <= '0;
         grp    <= '0;
         sh     <= '0;
         cs_q   <= 1'b1;
         dout_q <= '0;
         oe_q   <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (cmd_valid) begin
                  case (dec.kind)
                     K_CS_HI: cs_q <= 1'b1;
                     K_CS_LO: cs_q <= 1'b0;
                     K_SEND, K_RECV, K_SEND_TURN: begin
                        if (cmd_cnt != '0) begin
                           kind   <= dec.kind;
                           lanes  <= dec.lanes;
                           remain <= cmd_cnt;
                           st     <= ST_LOAD;
                        end
                     end
                     default: ;
                  endcase
               end
            end
            ST_LOAD: begin
               if (load_ok) begin
                  grp <= grp_last;
                  if (is_out) begin
                     sh     <= shifted;
                     dout_q <= grp_out;
                     oe_q   <= oe_mask;
                  end else begin
                     oe_q <= '0;
                  end
                  st <= ST_LO;
               end
            end
            ST_LO: st <= ST_HI;
            ST_HI: begin
               if (grp != 3'd0) begin
                  grp <= grp - 3'd1;
                  sh  <= shifted;
                  if (is_out) dout_q <= grp_out;
                  st <= ST_LO;
               end else begin
                  remain <= remain - 1'b1;
                  if (remain == CNT_W'(1)) begin
                     st <= ST_IDLE;
                     if (kind == K_SEND_TURN) oe_q <= '0;
                  end else begin
                     st <= ST_LOAD;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R12: the clock high phase is a single system cycle
   assert_sclk_half_R12: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |=> !sclk);

   // R12: lanes and enables hold while the clock is high
   assert_data_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> ($stable(dq_out) && $stable(dq_oe)));

   // R4: bytes are only captured with every lane released
   assert_half_duplex_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> (dq_oe == '0));

   // R9: an empty transmit queue holds the clock low
   assert_tx_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOAD && is_out && tx_empty) |=> (st == ST_LOAD && !sclk));

   // R10: a full receive queue holds the clock low
   assert_rx_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOAD && !is_out && rx_full) |=> (st == ST_LOAD && !sclk));

   // R2: chip select only moves when a command is taken from idle
   assert_cs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE) |=> $stable(cs_n));

   // R11: an undefined opcode touches no pin
   assert_undef_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && cmd_valid && dec.kind == K_NONE) |=>
         (st == ST_IDLE && $stable(dq_oe) && $stable(dq_out) && $stable(cs_n)));

endmodule

// File: rtl/spi_opseq.sv
module spi_opseq
   import spi_opseq_pkg::*;
#(
   parameter int CMD_DEPTH = 8,
   parameter int TX_DEPTH  = 16,
   parameter int RX_DEPTH  = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [13:0]  cmd_wdata,
   input  logic         cmd_push,
   output logic         cmd_full,
   output logic         cmd_empty,
   input  logic [7:0]   tx_wdata,
   input  logic         tx_push,
   output logic         tx_full,
   output logic [7:0]   rx_rdata,
   input  logic         rx_pop,
   output logic         rx_empty,
   output logic         sclk,
   output logic         cs_n,
   output logic [3:0]   dq_out,
   output logic [3:0]   dq_oe,
   input  logic [3:0]   dq_in
);

   generate
      if (CMD_W != 14 || BYTE_W != 8 || LANE_N != 4) begin : g_bad_shape
         $error("spi_opseq: port shape does not match package widths");
      end
   endgenerate

   logic [CMD_W-1:0]  cmd_head;
   logic              cmd_fifo_empty, cmd_pop;
   logic [BYTE_W-1:0] tx_head, rx_data;
   logic              tx_empty, tx_pop, rx_full, rx_push, busy;

   spi_opseq_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
      .clk(clk), .rst_n(rst_n),
      .push(cmd_push), .wdata(cmd_wdata),
      .pop(cmd_pop), .head(cmd_head),
      .full(cmd_full), .empty(cmd_fifo_empty)
   );

   spi_opseq_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .wdata(tx_wdata),
      .pop(tx_pop), .head(tx_head),
      .full(tx_full), .empty(tx_empty)
   );

   spi_opseq_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .wdata(rx_data),
      .pop(rx_pop), .head(rx_rdata),
      .full(rx_full), .empty(rx_empty)
   );

   spi_opseq_engine u_engine (
      .clk(clk), .rst_n(rst_n),
      .cmd_head(cmd_head), .cmd_valid(!cmd_fifo_empty), .cmd_pop(cmd_pop),
      .tx_head(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
      .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
      .sclk(sclk), .cs_n(cs_n), .dq_out(dq_out), .dq_oe(dq_oe),
      .dq_in(dq_in), .busy(busy)
   );

   assign cmd_empty = cmd_fifo_empty && !busy;

   // R6: a reported completion never coincides with clock activity
   assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_empty |-> !sclk);

   // R6: an empty flag is never raised while a command is in the queue
   assert_done_queue_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_empty |-> cmd_fifo_empty);

endmodule

// File: tb/spi_opseq_bench.sv
`timescale 1ns/1ps
module spi_opseq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] cmd_wdata = '0;
   logic        cmd_push = 1'b0;
   logic        cmd_full, cmd_empty;
   logic [7:0]  tx_wdata = '0;
   logic        tx_push = 1'b0;
   logic        tx_full;
   logic [7:0]  rx_rdata;
   logic        rx_pop = 1'b0;
   logic        rx_empty;
   logic        sclk, cs_n;
   logic [3:0]  dq_out, dq_oe, dq_in;

   int nchk = 0;
   int nerr = 0;

   always #5 clk = ~clk;

   spi_opseq #(.CMD_DEPTH(4), .TX_DEPTH(4), .RX_DEPTH(4)) u_spi_opseq (
      .clk(clk), .rst_n(rst_n),
      .cmd_wdata(cmd_wdata), .cmd_push(cmd_push),
      .cmd_full(cmd_full), .cmd_empty(cmd_empty),
      .tx_wdata(tx_wdata), .tx_push(tx_push), .tx_full(tx_full),
      .rx_rdata(rx_rdata), .rx_pop(rx_pop), .rx_empty(rx_empty),
      .sclk(sclk), .cs_n(cs_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
   );

   // lane model: mw 0 = one lane, 1 = two lanes, 2 = four lanes
   logic [1:0]  mw = 2'd0;
   logic [63:0] mon_bits = '0;
   int          mon_edges = 0;
   logic [63:0] slv = '0;
   int          hi_run = 0;
   int          max_hi = 0;

   always @(posedge sclk) begin
      mon_edges = mon_edges + 1;
      case (mw)
         2'd0:    mon_bits = {mon_bits[62:0], dq_out[0]};
         2'd1:    mon_bits = {mon_bits[61:0], dq_out[1:0]};
         default: mon_bits = {mon_bits[59:0], dq_out[3:0]};
      endcase
   end

   always @(negedge sclk) begin
      case (mw)
         2'd0:    slv = slv << 1;
         2'd1:    slv = slv << 2;
         default: slv = slv << 4;
      endcase
   end

   always_comb begin
      case (mw)
         2'd0:    dq_in = {2'b00, slv[63], 1'b0};
         2'd1:    dq_in = {2'b00, slv[63:62]};
         default: dq_in = slv[63:60];
      endcase
   end

   always @(negedge clk) begin
      if (sclk) hi_run = hi_run + 1;
      else hi_run = 0;
      if (hi_run > max_hi) max_hi = hi_run;
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push_cmd(input logic [4:0] op, input logic [8:0] cnt);
      @(negedge clk);
      cmd_wdata = {op, cnt};
      cmd_push  = 1'b1;
      @(negedge clk);
      cmd_push  = 1'b0;
   endtask

   task automatic push_tx(input logic [7:0] b);
      @(negedge clk);
      tx_wdata = b;
      tx_push  = 1'b1;
      @(negedge clk);
      tx_push  = 1'b0;
   endtask

   task automatic pop_rx();
      @(negedge clk);
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
   endtask

   task automatic wait_done();
      while (!cmd_empty) @(negedge clk);
   endtask

   // {opcode[26:22], lane width[21:20], tx byte[19:12], slave byte[11:4], dq_oe after[3:0]}
   localparam logic [26:0] VEC [9] = '{
      {5'h08, 2'd0, 8'hA5, 8'h00, 4'h1},
      {5'h09, 2'd1, 8'h3C, 8'h00, 4'h3},
      {5'h0A, 2'd2, 8'hE1, 8'h00, 4'hF},
      {5'h0C, 2'd0, 8'h00, 8'h96, 4'h0},
      {5'h0E, 2'd1, 8'h00, 8'h5A, 4'h0},
      {5'h0F, 2'd2, 8'h00, 8'hC3, 4'h0},
      {5'h10, 2'd0, 8'h81, 8'h00, 4'h0},
      {5'h11, 2'd1, 8'h7E, 8'h00, 4'h0},
      {5'h12, 2'd2, 8'h18, 8'h00, 4'h0}
   };

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL R6 watchdog: actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [3:0] oe_keep, dout_keep;
      logic       cs_keep;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 cs_n", cs_n, 1);
      check("R1 sclk", sclk, 0);
      check("R1 dq_oe", dq_oe, 0);
      check("R1 cmd_empty", cmd_empty, 1);
      check("R1 rx_empty", rx_empty, 1);
      check("R1 tx_full", tx_full, 0);

      // R2 chip select low, data pins untouched
      push_cmd(5'h01, 9'd1);
      wait_done();
      check("R2 cs low", cs_n, 0);
      check("R2 oe kept", dq_oe, 0);

      // table walk: R3 send, R4 receive, R5 turnaround, R12 edge counts
      for (int i = 0; i < 9; i++) begin
         logic [4:0] op;
         logic       is_in;
         string      tag;
         op    = VEC[i][26:22];
         mw    = VEC[i][21:20];
         is_in = (op == 5'h0C) || (op == 5'h0E) || (op == 5'h0F);
         tag   = is_in ? "R4" : ((op >= 5'h10) ? "R5" : "R3");
         mon_edges = 0;
         mon_bits  = '0;
         slv       = {VEC[i][11:4], 56'h0};
         if (!is_in) push_tx(VEC[i][19:12]);
         push_cmd(op, 9'd1);
         wait_done();
         if (is_in) begin
            check({tag, " rx present"}, rx_empty, 0);
            check({tag, " rx byte"}, rx_rdata, VEC[i][11:4]);
            pop_rx();
         end else begin
            check({tag, " tx byte"}, mon_bits[7:0], VEC[i][19:12]);
         end
         check({tag, " dq_oe after"}, dq_oe, VEC[i][3:0]);
         check("R12 edges per byte", mon_edges, 8 >> mw);
      end

      // R9 and R6: send stalls with no data, completion waits for it
      mw = 2'd0;
      mon_edges = 0;
      mon_bits  = '0;
      push_cmd(5'h08, 9'd2);
      repeat (20) @(negedge clk);
      check("R6 busy while stalled", cmd_empty, 0);
      check("R9 no clock while tx empty", mon_edges, 0);
      push_tx(8'hC3);
      push_tx(8'h3C);
      wait_done();
      check("R9 resumed bytes", mon_bits[15:0], 16'hC33C);
      check("R6 done", cmd_empty, 1);

      // R8: full flag and dropped push
      push_tx(8'h01);
      push_tx(8'h02);
      push_tx(8'h03);
      check("R8 not full at 3", tx_full, 0);
      push_tx(8'h04);
      check("R8 full at 4", tx_full, 1);
      push_tx(8'h05);
      mon_bits  = '0;
      mon_edges = 0;
      push_cmd(5'h08, 9'd4);
      wait_done();
      check("R8 four bytes out", mon_bits[31:0], 32'h01020304);
      mon_edges = 0;
      push_cmd(5'h08, 9'd1);
      repeat (20) @(negedge clk);
      check("R8 dropped byte absent", mon_edges, 0);
      push_tx(8'h55);
      wait_done();
      check("R8 later byte", mon_bits[7:0], 8'h55);

      // R7: receive queue order
      mw  = 2'd0;
      slv = 64'h112233_0000000000;
      push_cmd(5'h0C, 9'd3);
      wait_done();
      check("R7 head 1", rx_rdata, 8'h11);
      pop_rx();
      check("R7 head 2", rx_rdata, 8'h22);
      pop_rx();
      check("R7 head 3", rx_rdata, 8'h33);
      pop_rx();
      check("R7 drained", rx_empty, 1);

      // R10: receive stalls on a full queue
      mw  = 2'd1;
      slv = 64'hA1A2A3A4A5A6_0000;
      mon_edges = 0;
      push_cmd(5'h0E, 9'd6);
      repeat (60) @(negedge clk);
      check("R10 busy while rx full", cmd_empty, 0);
      check("R10 edges stop at 4 bytes", mon_edges, 16);
      for (int k = 0; k < 6; k++) begin
         while (rx_empty) @(negedge clk);
         check("R10 rx byte", rx_rdata, 8'hA1 + k);
         pop_rx();
      end
      wait_done();
      check("R10 total edges", mon_edges, 24);

      // R11: undefined opcodes and zero counts
      mw = 2'd0;
      push_tx(8'hF0);
      push_cmd(5'h08, 9'd1);
      wait_done();
      oe_keep   = dq_oe;
      dout_keep = dq_out;
      cs_keep   = cs_n;
      mon_edges = 0;
      push_cmd(5'h03, 9'd5);
      push_cmd(5'h1F, 9'h1FF);
      push_cmd(5'h10, 9'd0);
      push_cmd(5'h0F, 9'd0);
      wait_done();
      check("R11 oe", dq_oe, oe_keep);
      check("R11 oe still driving", dq_oe, 4'h1);
      check("R11 dq_out", dq_out, dout_keep);
      check("R11 cs", cs_n, cs_keep);
      check("R11 no clock", mon_edges, 0);
      check("R11 no rx", rx_empty, 1);

      // R2 chip select high
      push_cmd(5'h00, 9'd1);
      wait_done();
      check("R2 cs high", cs_n, 1);

      check("R12 high phase length", max_hi, 1);

      summary();
      $finish;
   end

endmodule